// File: doc/BRIEF.md
# Single-Bit Boolean Flag Unit

This execution unit works on one bit of an 8-bit operand and on the condition flags of a small processor core. A 3-bit index picks one bit of the operand. An operation code then picks one of seven actions:

- three actions that treat carry as a one-bit accumulator: AND, OR and XOR of the chosen bit into carry;
- a load of the chosen bit into carry;
- a test that puts the inverse of the chosen bit into zero;
- two stores that write carry, or the zero flag, back into the chosen bit of the byte.

The surrounding pipeline fetches the operand and supplies the current flags. It takes back the registered flags and byte, and it writes the byte to its home when the write-enable is high.

All results are registered on the clock edge where the valid strobe is high. Between strobes the outputs hold. A flag that an operation does not name passes through from its input exactly.

Top module: `bitop_flag_unit`

## Requirements
- R1: `bit_idx` selects bit 0 (value 0) through bit 7 (value 7) of `data_in` as the operand bit for every operation.
- R2: Operation code 0 (AND) sets carry to `c_in` AND the selected bit; zero is passed through unchanged.
- R3: Operation code 1 (OR) sets carry to `c_in` OR the selected bit, so a set carry is never cleared.
- R4: Operation code 2 (XOR) sets carry to `c_in` XOR the selected bit.
- R5: Operation code 3 (LOAD) sets carry to the selected bit, whatever `c_in` is.
- R6: Operation code 4 (STORE) returns `data_in` with the selected bit replaced by `c_in`. The other seven bits are unchanged, and carry and zero pass through.
- R7: Operation code 5 (STORE-ZERO) returns `data_in` with the selected bit replaced by `z_in`, and all flags pass through unchanged.
- R8: Operation code 6 (TEST) sets zero to the inverse of the selected bit. Carry passes through, and `data_we` stays low.
- R9: No operation alters negative or overflow; `n_out`/`v_out` take `n_in`/`v_in` on every valid cycle.
- R10: Results appear one cycle after a valid strobe. `data_out` then carries the operand, modified only by a store, and `data_we` is high only for codes 4 and 5.
- R11: Operation code 7 is undefined: all flags pass through unchanged and `data_we` stays low.
- R12: With `in_valid` low, the flags and `data_out` hold and `data_we` is low.
- R13: Synchronous active-high `rst` clears all four flags, `data_out` and `data_we`, and takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (0 AND, 1 OR, 2 XOR, 3 LOAD, 4 STORE, 5 STORE-ZERO, 6 TEST) |
| bit_idx | input | 3 | Selected bit position |
| data_in | input | 8 | Operand byte |
| c_in | input | 1 | Current carry |
| z_in | input | 1 | Current zero |
| n_in | input | 1 | Current negative |
| v_in | input | 1 | Current overflow |
| c_out | output | 1 | Updated carry |
| z_out | output | 1 | Updated zero |
| n_out | output | 1 | Updated negative |
| v_out | output | 1 | Updated overflow |
| data_out | output | 8 | Operand byte, modified by stores |
| data_we | output | 1 | Byte write-enable, one cycle after a store |

## Verification
Every result of this unit appears exactly one clock edge after the strobe that caused it: the four flags, the byte and the write-enable. The hold behaviour of an idle cycle is likewise visible one edge later. The driver applies each operation at a falling edge and queues the expected result for that cycle. The monitor pops one entry a short delay after each rising edge, so the comparison always lands in the cycle the registers update and never in the same time step as the edge.

// File: rtl/bitop_flag_unit.sv
module bitop_flag_unit #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op_code,
  input  logic [IW-1:0] bit_idx,
  input  logic [W-1:0]  data_in,
  input  logic          c_in,
  input  logic          z_in,
  input  logic          n_in,
  input  logic          v_in,
  output logic          c_out,
  output logic          z_out,
  output logic          n_out,
  output logic          v_out,
  output logic [W-1:0]  data_out,
  output logic          data_we
);
  localparam logic [2:0] OP_AND = 3'd0, OP_OR = 3'd1, OP_XOR = 3'd2, OP_LD = 3'd3,
                         OP_ST = 3'd4, OP_STZ = 3'd5, OP_TST = 3'd6;

  logic         sel;
  logic         c_nx, z_nx, we_nx;
  logic [W-1:0] d_nx;

  assign sel = data_in[bit_idx];

  always_comb begin
    c_nx  = c_in;
    z_nx  = z_in;
    d_nx  = data_in;
    we_nx = 1'b0;
    case (op_code)
      OP_AND: c_nx = c_in & sel;
      OP_OR:  c_nx = c_in | sel;
      OP_XOR: c_nx = c_in ^ sel;
      OP_LD:  c_nx = sel;
      OP_ST:  begin d_nx[bit_idx] = c_in; we_nx = 1'b1; end
      OP_STZ: begin d_nx[bit_idx] = z_in; we_nx = 1'b1; end
      OP_TST: z_nx = ~sel;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_out    <= 1'b0;
      z_out    <= 1'b0;
      n_out    <= 1'b0;
      v_out    <= 1'b0;
      data_out <= '0;
      data_we  <= 1'b0;
    end else begin
      data_we <= in_valid & we_nx;
      if (in_valid) begin
        c_out    <= c_nx;
        z_out    <= z_nx;
        n_out    <= n_in;
        v_out    <= v_in;
        data_out <= d_nx;
      end
    end
  end
endmodule

// File: rtl/bitop_flag_unit_chk.sv
module bitop_flag_unit_chk #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op_code,
  input logic [IW-1:0] bit_idx,
  input logic [W-1:0]  data_in,
  input logic          c_in,
  input logic          z_in,
  input logic          n_in,
  input logic          v_in,
  input logic          c_out,
  input logic          z_out,
  input logic          n_out,
  input logic          v_out,
  input logic [W-1:0]  data_out,
  input logic          data_we
);
  // R9
  nv_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (n_out == $past(n_in)) && (v_out == $past(v_in)));

  // R10
  we_only_store_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code != 3'd4 && op_code != 3'd5) |=> !data_we);

  // R6
  store_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 3'd4) |=>
      data_we && (data_out[$past(bit_idx)] == $past(c_in)) && (c_out == $past(c_in)));

  // R7
  store_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 3'd5) |=>
      data_we && (data_out[$past(bit_idx)] == $past(z_in)) &&
      (c_out == $past(c_in)) && (z_out == $past(z_in)));

  // R8
  test_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 3'd6) |=>
      (z_out == !$past(data_in[bit_idx])) && (c_out == $past(c_in)) && !data_we);

  // R11
  undef_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 3'd7) |=>
      (c_out == $past(c_in)) && (z_out == $past(z_in)) && !data_we);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(c_out) && $stable(z_out) && $stable(data_out) && !data_we);

  // R13
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !c_out && !z_out && !n_out && !v_out && !data_we && (data_out == '0));
endmodule

bind bitop_flag_unit bitop_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .bit_idx(bit_idx),
  .data_in(data_in), .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in),
  .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out),
  .data_out(data_out), .data_we(data_we)
);

// File: tb/sim_bitop_flag_unit.sv
`timescale 1ns/1ps
module sim_bitop_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [2:0] bit_idx = 3'd0;
  logic [7:0] data_in = 8'h00;
  logic c_in = 1'b0, z_in = 1'b0, n_in = 1'b0, v_in = 1'b0;
  logic c_out, z_out, n_out, v_out, data_we;
  logic [7:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [12:0] exp_q[$];
  string       tag_q[$];
  logic        mc = 0, mz = 0, mn = 0, mv = 0;
  logic [7:0]  md = 8'h00;

  always #4 clk = ~clk;

  bitop_flag_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .bit_idx(bit_idx),
    .data_in(data_in), .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in),
    .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out),
    .data_out(data_out), .data_we(data_we)
  );

  task automatic drive(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] d,
                       input logic c, input logic z, input logic n, input logic v,
                       input string tag);
    logic b, we;
    @(negedge clk);
    in_valid = 1'b1; op_code = op; bit_idx = idx; data_in = d;
    c_in = c; z_in = z; n_in = n; v_in = v;
    b = d[idx];
    mc = c; mz = z; mn = n; mv = v; md = d; we = 1'b0;
    case (op)
      3'd0: mc = c & b;
      3'd1: mc = c | b;
      3'd2: mc = c ^ b;
      3'd3: mc = b;
      3'd4: begin md[idx] = c; we = 1'b1; end
      3'd5: begin md[idx] = z; we = 1'b1; end
      3'd6: mz = ~b;
      default: ;
    endcase
    exp_q.push_back({mc, mz, mn, mv, md, we});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 1'b0; op_code = 3'd4; data_in = 8'hFF; c_in = ~mc; z_in = ~mz;
    exp_q.push_back({mc, mz, mn, mv, md, 1'b0});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      logic [12:0] e;
      logic [12:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {c_out, z_out, n_out, v_out, data_out, data_we};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual c%b z%b n%b v%b d=%h we%b expected c%b z%b n%b v%b d=%h we%b",
                 t, a[12], a[11], a[10], a[9], a[8:1], a[0],
                 e[12], e[11], e[10], e[9], e[8:1], e[0]);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; op_code = 3'd3; data_in = 8'hFF; c_in = 1; z_in = 1; n_in = 1; v_in = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    // R13 reset wins over a valid strobe
    if ({c_out, z_out, n_out, v_out, data_out, data_we} !== 13'd0) begin
      errors++;
      $display("FAIL R13 actual=%h expected=0", {c_out, z_out, n_out, v_out, data_out, data_we});
    end
    rst = 1'b0;
    in_valid = 1'b0;

    drive(3'd0, 3'd7, 8'hA5, 1, 0, 0, 0, "R2 and bit7 keeps carry");
    drive(3'd0, 3'd6, 8'hA5, 1, 0, 1, 1, "R2 and bit6 clears carry");
    drive(3'd0, 3'd7, 8'hA5, 0, 1, 0, 0, "R2 and never sets carry");
    drive(3'd1, 3'd6, 8'hA5, 0, 0, 0, 1, "R3 or zero bit");
    drive(3'd1, 3'd7, 8'hA5, 0, 0, 1, 0, "R3 or sets carry");
    drive(3'd1, 3'd6, 8'hA5, 1, 0, 0, 0, "R3 or keeps set carry");
    drive(3'd2, 3'd6, 8'hA5, 1, 0, 0, 0, "R4 xor zero bit keeps carry");
    drive(3'd2, 3'd7, 8'hA5, 1, 1, 1, 1, "R4 xor one bit clears carry");
    drive(3'd2, 3'd0, 8'hA5, 0, 0, 0, 0, "R4 xor one bit sets carry");
    drive(3'd3, 3'd7, 8'hA5, 0, 0, 0, 0, "R5 load one");
    drive(3'd3, 3'd6, 8'hA5, 1, 1, 0, 0, "R5 load zero");
    drive(3'd4, 3'd7, 8'hA5, 0, 0, 0, 0, "R6 store clear bit7");
    drive(3'd4, 3'd6, 8'h25, 1, 0, 1, 1, "R6 store set bit6");
    drive(3'd5, 3'd6, 8'h25, 0, 1, 0, 0, "R7 store zero flag set");
    drive(3'd5, 3'd0, 8'hA5, 1, 0, 1, 0, "R7 store zero flag clear");
    drive(3'd6, 3'd7, 8'hA5, 1, 1, 0, 0, "R8 test one bit");
    drive(3'd6, 3'd6, 8'hA5, 1, 0, 1, 1, "R8 test zero bit");
    for (int i = 0; i < 8; i++)
      drive(3'd3, 3'(i), 8'h01 << i, 0, 0, 0, 0, "R1 bit index walk");
    drive(3'd7, 3'd2, 8'h5A, 1, 1, 1, 1, "R11 undefined code");
    drive(3'd4, 3'd3, 8'h00, 1, 0, 1, 0, "R10 store then idle");
    idle("R12 idle hold after store");
    idle("R12 idle hold second");
    drive(3'd6, 3'd1, 8'h02, 0, 0, 1, 1, "R9 negative overflow untouched");
    drive(3'd0, 3'd1, 8'h02, 1, 1, 0, 0, "R9 negative overflow clear passes");
    idle("R12 final idle");
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule